// File: doc/BRIEF.md
# Three-Wire Real-Time-Clock Serial Controller

This block is the master side of a three-wire serial link to a battery-backed real-time-clock device. It drives a chip-enable line and a serial clock, and it handles a single data line. The data line comes out as three separate signals: the level driven, the drive enable and the level sensed. A pad buffer at the top level joins them. Each accepted request runs exactly one transaction. The block first shifts out a command byte. It then either shifts out one data byte (a write) or takes in one byte from the device (a read).

The controller is a three-state machine. In `ST_IDLE` it waits for a request. The *accept* transition, taken on `req`, moves it to `ST_XFER`. In `ST_XFER` chip enable is high and a stream of equal half-periods of the serial clock is produced. The *finish* transition, taken on the tick that ends the last half-period, moves it to `ST_GAP` and fires `done`. In `ST_GAP` chip enable is held low for a recovery time. The *release* transition then returns it to `ST_IDLE`. Both the half-period and the recovery time are parameters counted in system clock cycles. The defaults suit a 50 MHz system clock: a 1 µs half-period and a 4 µs gap.

Top module: `rtc3w_ctrl`

## Requirements
- R1: `ce` is high only while a transaction runs. It stays high for 33 half-periods on a write and 31 on a read. `sclk` is low whenever `ce` is low.
- R2: The command byte is built as follows. Bit 7 is always 1. Bit 6 is `req_ram`. Bits 5..1 are `req_addr`. Bit 0 is 1 for a read and 0 for a write. For example, a read of address 0 in clock space gives 0x81, and a write of address 1 gives 0x82.
- R3: Every byte on the line, command or data, goes least-significant bit first.
- R4: A write gives 16 rising `sclk` edges per `ce` window. The first 8 carry the command and the next 8 carry `req_wdata`. `sio_o` changes only while `sclk` is low, so it is stable at each rising edge.
- R5: A read gives 15 rising `sclk` edges. The device drives a new bit after each falling edge from the 8th rising edge on. Bit k of the returned byte is sampled one half-period after the falling edge that follows rising edge 8+k. The sampled byte is presented on `rdata`.
- R6: During a read, `sio_oe` drops at the falling edge after the 8th rising edge. It stays low until `ce` falls, which is 15 half-periods in all. During a write, `sio_oe` is high for the whole window. `sio_oe` is never high while `ce` is low.
- R7: Every interval between consecutive `ce`/`sclk` transitions inside a window is `HALF_CYC` system cycles. This includes the interval from the rise of `ce` to the first rising edge, and from the last falling edge to the fall of `ce`.
- R8: `ce` stays low for at least `GAP_CYC` cycles between transactions. `busy` is high from acceptance until the gap ends.
- R9: A `req` that arrives while `busy` is high is ignored. It starts no extra transaction and does not change the running one.
- R10: `done` is a single-cycle pulse in the cycle `ce` falls. `rdata` is valid with it. `rdata` then holds until the next read completes, and writes leave it unchanged.
- R11: After reset, `ce`, `sclk`, `sio_oe`, `busy` and `done` are low, and `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start a transaction (taken only when idle) |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_ram | input | 1 | 1 = scratch RAM space, 0 = clock register space |
| req_addr | input | 5 | Register address |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | Transaction or recovery gap in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last byte read |
| ce | output | 1 | Chip enable to the device |
| sclk | output | 1 | Serial clock to the device |
| sio_o | output | 1 | Level driven onto the data line |
| sio_oe | output | 1 | Drive enable for the data line |
| sio_i | input | 1 | Level sensed on the data line |

## Verification
A behavioural device on the bench decodes every window at the pins. It checks the command byte against the fields requested, which catches a reversed bit order or a misplaced field. It also counts rising edges, so a write cut to 15 clocks or a read run to 16 shows up as a wrong count. The device drives read bits on falling edges. The bench flags any cycle in which both sides drive the line, so an early or late release of `sio_oe` is caught. It also checks that `rdata` matches the bench's own copy of the device memory, which catches a sample taken on the wrong half-period (the byte comes back shifted). Requests are also pulsed in the middle of transactions to expose a restart. Half-period and gap intervals are timed, and transactions are issued back to back, to catch an off-by-one in the divider or the recovery counter.

// File: rtl/rtc3w_pkg.sv
package rtc3w_pkg;

    localparam int ADDR_W      = 5;
    localparam int BYTE_W      = 8;
    localparam int WR_CLOCKS   = 2 * BYTE_W;       // command + data out
    localparam int RD_CLOCKS   = 2 * BYTE_W - 1;   // last data bit needs no rise
    localparam int LAST_WR_SEG = 2 * WR_CLOCKS;    // trailing low half-period
    localparam int LAST_RD_SEG = 2 * RD_CLOCKS;
    localparam int TURN_SEG    = 2 * BYTE_W;       // first half-period owned by device
    localparam int SEG_W       = $clog2(LAST_WR_SEG + 1);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_GAP  = 2'd2
    } rtc3w_state_e;

    function automatic logic [BYTE_W-1:0] make_cmd(
        input logic              rd,
        input logic              ram,
        input logic [ADDR_W-1:0] addr
    );
        return {1'b1, ram, addr, rd};
    endfunction

endpackage

// File: rtl/rtc3w_divider.sv
module rtc3w_divider #(
    parameter int HALF_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(HALF_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || cnt_q == CNT_TOP) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == CNT_TOP);

endmodule

// File: rtl/rtc3w_tx_shift.sv
module rtc3w_tx_shift #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             shift,
    output logic             bit_o
);
    logic [WIDTH-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= load_val;
        end else if (shift) begin
            sr_q <= {1'b0, sr_q[WIDTH-1:1]};
        end
    end

    assign bit_o = sr_q[0];

endmodule

// File: rtl/rtc3w_rx_capture.sv
module rtc3w_rx_capture #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift,
    input  logic             commit,
    input  logic             din,
    output logic [WIDTH-1:0] byte_o
);
    logic [WIDTH-1:0] sr_q;
    logic [WIDTH-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q   <= '0;
            hold_q <= '0;
        end else begin
            if (shift) begin
                sr_q <= {din, sr_q[WIDTH-1:1]};
            end
            if (commit) begin
                hold_q <= {din, sr_q[WIDTH-1:1]};
            end
        end
    end

    assign byte_o = hold_q;

endmodule

// File: rtl/rtc3w_ctrl.sv
module rtc3w_ctrl
    import rtc3w_pkg::*;
#(
    parameter int HALF_CYC = 50,
    parameter int GAP_CYC  = 200
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        req_rd,
    input  logic        req_ram,
    input  logic [4:0]  req_addr,
    input  logic [7:0]  req_wdata,
    output logic        busy,
    output logic        done,
    output logic [7:0]  rdata,
    output logic        ce,
    output logic        sclk,
    output logic        sio_o,
    output logic        sio_oe,
    input  logic        sio_i
);
    localparam int GAP_W = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
    localparam logic [GAP_W-1:0] GAP_TOP  = GAP_W'(GAP_CYC - 1);
    localparam logic [SEG_W-1:0] SEG_WR   = SEG_W'(LAST_WR_SEG);
    localparam logic [SEG_W-1:0] SEG_RD   = SEG_W'(LAST_RD_SEG);
    localparam logic [SEG_W-1:0] SEG_TURN = SEG_W'(TURN_SEG);

    rtc3w_state_e       state_q, state_d;
    logic [SEG_W-1:0]   seg_q;
    logic [GAP_W-1:0]   gap_q;
    logic               rd_q;
    logic               done_q;
    logic               tick;
    logic               accept;
    logic               last_seg;
    logic               seg_end;
    logic               dev_owns;
    logic               tx_bit;

    assign accept   = (state_q == ST_IDLE) && req;
    assign last_seg = rd_q ? (seg_q == SEG_RD) : (seg_q == SEG_WR);
    assign seg_end  = (state_q == ST_XFER) && tick && last_seg;
    assign dev_owns = rd_q && (seg_q >= SEG_TURN);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req)              state_d = ST_XFER;
            ST_XFER: if (seg_end)          state_d = ST_GAP;
            ST_GAP:  if (gap_q == GAP_TOP) state_d = ST_IDLE;
            default:                       state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // sequencing counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_q  <= '0;
            gap_q  <= '0;
            rd_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= seg_end;
            if (accept) begin
                seg_q <= '0;
                rd_q  <= req_rd;
            end else if ((state_q == ST_XFER) && tick && !last_seg) begin
                seg_q <= seg_q + 1'b1;
            end
            if (state_q == ST_GAP) begin
                gap_q <= gap_q + 1'b1;
            end else begin
                gap_q <= '0;
            end
        end
    end

    rtc3w_divider #(.HALF_CYC(HALF_CYC)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_XFER),
        .tick  (tick)
    );

    rtc3w_tx_shift #(.WIDTH(2 * BYTE_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val ({req_wdata, make_cmd(req_rd, req_ram, req_addr)}),
        .shift    ((state_q == ST_XFER) && tick && seg_q[0]),
        .bit_o    (tx_bit)
    );

    rtc3w_rx_capture #(.WIDTH(BYTE_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .shift  ((state_q == ST_XFER) && tick && dev_owns && !seg_q[0]),
        .commit (seg_end && rd_q),
        .din    (sio_i),
        .byte_o (rdata)
    );

    // outputs
    always_comb begin
        ce     = (state_q == ST_XFER);
        sclk   = ce && seg_q[0];
        sio_oe = ce && !dev_owns;
        sio_o  = tx_bit;
        busy   = (state_q != ST_IDLE);
        done   = done_q;
    end

endmodule

// File: rtl/rtc3w_checks.sv
module rtc3w_checks #(
    parameter int GAP_CYC = 200
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic ce,
    input logic sclk,
    input logic sio_o,
    input logic sio_oe
);
    int low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= GAP_CYC;
        end else if (ce) begin
            low_cnt <= 0;
        end else if (low_cnt < GAP_CYC) begin
            low_cnt <= low_cnt + 1;
        end
    end

    a_r1_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |-> !sclk);

    a_r4_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        sclk && $past(sclk) |-> $stable(sio_o));

    a_r6_oe_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
        sio_oe |-> ce);

    a_r6_no_reclaim: assert property (@(posedge clk) disable iff (!rst_n)
        ce && $past(ce) && !$past(sio_oe) |-> !sio_oe);

    a_r8_gap_kept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ce) |-> low_cnt >= GAP_CYC);

    a_r8_busy_covers_ce: assert property (@(posedge clk) disable iff (!rst_n)
        ce |-> busy);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_done_at_ce_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ce) |-> done);

endmodule

bind rtc3w_ctrl rtc3w_checks #(.GAP_CYC(GAP_CYC)) u_checks (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .done   (done),
    .ce     (ce),
    .sclk   (sclk),
    .sio_o  (sio_o),
    .sio_oe (sio_oe)
);

// File: tb/rtc3w_ctrl_test.sv
`timescale 1ns/1ps
module rtc3w_ctrl_test;
    localparam int HALF = 3;
    localparam int GAP  = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0, req_rd = 1'b0, req_ram = 1'b0;
    logic [4:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       busy, done, ce, sclk, sio_o, sio_oe;
    logic [7:0] rdata;
    logic       sio_i = 1'b0;

    always #5 clk = ~clk;

    rtc3w_ctrl #(.HALF_CYC(HALF), .GAP_CYC(GAP)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_rd(req_rd), .req_ram(req_ram),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rdata(rdata), .ce(ce), .sclk(sclk), .sio_o(sio_o), .sio_oe(sio_oe),
        .sio_i(sio_i)
    );

    int n_chk = 0, n_bad = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] seed_byte(int idx);
        return 8'((idx * 37 + 5) ^ (idx << 3));
    endfunction

    // ---------------- behavioural device ----------------
    logic [7:0] dev_mem [64];
    logic       dev_init = 1'b0;
    logic [7:0] s_cmd, s_wd;
    int         s_rises = 0, s_txn = 0;
    logic       drv = 1'b0, oe_bad = 1'b0;
    logic       ce_m = 1'b0, sclk_m = 1'b0;

    always @(ce or sclk) begin
        if (!dev_init) begin
            for (int i = 0; i < 64; i++) dev_mem[i] = seed_byte(i);
            dev_init = 1'b1;
        end
        if (ce && !ce_m) begin
            s_rises = 0; s_cmd = '0; s_wd = '0; drv = 1'b0; oe_bad = 1'b0;
            s_txn++;
        end
        if (ce && sclk && !sclk_m) begin
            if (s_rises < 8) begin
                s_cmd[s_rises] = sio_o;
                if (!sio_oe) oe_bad = 1'b1;
            end else if (!s_cmd[0] && s_rises < 16) begin
                s_wd[s_rises-8] = sio_o;
                if (!sio_oe) oe_bad = 1'b1;
            end
            s_rises++;
        end
        if (ce && !sclk && sclk_m && s_cmd[0] && s_rises >= 8 && s_rises <= 15) begin
            drv   = 1'b1;
            sio_i = dev_mem[s_cmd[6:1]][s_rises-8];
        end
        if (!ce && ce_m) begin
            drv   = 1'b0;
            sio_i = 1'b0;
            if (!s_cmd[0] && s_cmd[7]) dev_mem[s_cmd[6:1]] = s_wd;
        end
        ce_m   = ce;
        sclk_m = sclk;
    end

    // ---------------- per-cycle monitor ----------------
    int cyc = 0, last_ev = 0, fall_cyc = -1;
    int ce_high = 0, oe_low = 0;
    int sclk_bad = 0, half_bad = 0, gap_bad = 0, done_bad = 0, clash = 0;
    logic ce_p = 1'b0, sclk_p = 1'b0, done_p = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (ce) ce_high++;
            if (ce && !sio_oe) oe_low++;
            if (!ce && sclk) sclk_bad++;
            if (drv && sio_oe) clash++;
            if (done && done_p) done_bad++;
            if (!ce && ce_p && !done) done_bad++;
            if ((ce != ce_p) || (sclk != sclk_p)) begin
                if (ce_p && (cyc - last_ev) != HALF) half_bad++;
                last_ev = cyc;
            end
            if (ce && !ce_p && fall_cyc >= 0 && (cyc - fall_cyc) < GAP) gap_bad++;
            if (!ce && ce_p) fall_cyc = cyc;
        end
        ce_p = ce; sclk_p = sclk; done_p = done;
    end

    // ---------------- stimulus ----------------
    logic [7:0] exp_mem [64];
    logic [7:0] last_rd = 8'h00;
    logic       finished = 1'b0;

    task automatic run_txn(bit rd, bit ram, logic [4:0] addr, logic [7:0] wd, bit poke);
        int txn0;
        int guard;
        logic [7:0] exp_cmd;
        exp_cmd = {1'b1, ram, addr, rd};
        while (busy) @(negedge clk);
        ce_high = 0; oe_low = 0;
        txn0 = s_txn;
        req = 1'b1; req_rd = rd; req_ram = ram; req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req = 1'b0; req_rd = ~rd; req_addr = ~addr; req_wdata = ~wd;
        if (poke) begin
            repeat (5 + 2 * HALF) @(negedge clk);
            req = 1'b1; req_rd = ~rd; req_ram = ~ram; req_addr = addr ^ 5'd5;
            @(negedge clk);
            req = 1'b0;
        end
        guard = 0;
        while (!done && guard < 2000) begin @(negedge clk); guard++; end
        chk("R10 done seen", {31'd0, done}, 32'd1);
        chk("R2 R3 command byte", {24'd0, s_cmd}, {24'd0, exp_cmd});
        chk(rd ? "R5 read rising edges" : "R4 write rising edges", s_rises, rd ? 15 : 16);
        chk("R1 ce window length", ce_high, (rd ? 31 : 33) * HALF);
        chk("R6 release span", oe_low, rd ? 15 * HALF : 0);
        chk("R6 driven while master samples", {31'd0, oe_bad}, 32'd0);
        if (rd) begin
            last_rd = exp_mem[{ram, addr}];
            chk("R5 R10 read byte", {24'd0, rdata}, {24'd0, last_rd});
        end else begin
            chk("R3 R4 write byte", {24'd0, s_wd}, {24'd0, wd});
            exp_mem[{ram, addr}] = wd;
            chk("R10 rdata held over write", {24'd0, rdata}, {24'd0, last_rd});
        end
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        if (poke) chk("R9 request during busy ignored", s_txn - txn0, 1);
    endtask

    initial begin
        int unsigned sd;
        sd = $urandom(32'd4242);
        for (int i = 0; i < 64; i++) exp_mem[i] = seed_byte(i);
        repeat (4) @(negedge clk);
        chk("R11 reset ce", {31'd0, ce}, 0);
        chk("R11 reset sclk", {31'd0, sclk}, 0);
        chk("R11 reset oe", {31'd0, sio_oe}, 0);
        chk("R11 reset busy", {31'd0, busy}, 0);
        chk("R11 reset done", {31'd0, done}, 0);
        chk("R11 reset rdata", {24'd0, rdata}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        run_txn(1'b1, 1'b0, 5'd0, 8'h00, 1'b0);   // command 0x81
        chk("R2 read-seconds command value", {24'd0, s_cmd}, 32'h81);
        run_txn(1'b0, 1'b0, 5'd1, 8'h59, 1'b0);   // command 0x82
        chk("R2 write-minutes command value", {24'd0, s_cmd}, 32'h82);
        run_txn(1'b1, 1'b0, 5'd1, 8'h00, 1'b1);   // read back, with a stray request
        run_txn(1'b1, 1'b1, 5'd31, 8'h00, 1'b0);  // command 0xFF
        run_txn(1'b0, 1'b1, 5'd31, 8'hA5, 1'b1);
        run_txn(1'b1, 1'b1, 5'd31, 8'h00, 1'b0);

        for (int n = 0; n < 40; n++) begin
            run_txn(1'($urandom()), 1'($urandom()), 5'($urandom()),
                    8'($urandom()), ($urandom() % 4) == 0);
        end

        chk("R1 sclk low while ce low", sclk_bad, 0);
        chk("R7 half-period timing", half_bad, 0);
        chk("R8 recovery gap", gap_bad, 0);
        chk("R10 done pulse shape", done_bad, 0);
        chk("R6 no bus contention", clash, 0);
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1500000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=hung expected=complete");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule